// File: doc/BRIEF.md
# CAN Error Flag Register Bank

This block holds the error-reporting registers of a CAN controller. The bit engine delivers one-cycle pulses for protocol errors and bus-state events. The block latches them into an error flag register and an error code register. A per-flag enable register selects which flags reach a single error summary bit, and that bit appears in an interrupt status register. A separate interrupt enable bit then gates the summary onto the interrupt line. The transmit and receive error counters come in as plain values. The block compares them against the warning and passive thresholds, drives level outputs from the result, and raises a flag on each upward crossing.

Software uses a byte-wide register bus with a combinational read port. Flags and error codes are cleared by writing 0 to their bit, so a single byte write can clear one flag and leave the rest alone. The code register has two display modes. In one, error codes collect until software clears them. In the other, only the most recent error's bits are shown.

Top module: `can_err_bank`

## Requirements
- R1: After reset every register reads 0x00, errIrq is 0, and all flags, enables and codes are clear.
- R2: Flag register (address 0) layout, bit 7 down to 0: bus lock, overload sent, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error. stateEvt[4:0] sets bits 7..3 in that order, and any codeEvt pulse sets bit 0. Each flag is visible on the clock edge after its pulse.
- R3: A write to the flag register clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R4: When a set pulse arrives in the same cycle as a software clear of that flag, the flag ends up set.
- R5: The enable register (address 1) has one enable per flag at the same bit positions. Bit 5 of the status register (address 3) is the OR over all flags ANDed with their enables, and it drops as soon as the last enabled flag is cleared.
- R6: errIrq is 1 exactly when the status summary bit is 1 and bit 5 of the interrupt enable register (address 4) is 1. Only bit 5 of that register is stored, and it reads back at bit 5.
- R7: warnActive is 1 when either error counter is above 96. A counter at exactly 96 does not qualify. The error warning flag is set once, on the cycle after warnActive rises, and is not set again while warnActive stays high.
- R8: passActive is 1 when either counter is above 127. A counter at exactly 127 does not qualify. The error passive flag is set once, on the cycle after passActive rises.
- R9: Code register (address 2) layout, bit 7 down to 0: display mode, ACK delimiter error, bit error dominant, bit error recessive, CRC error, ACK error, form error, stuff error. codeEvt[6:0] maps to bits 6..0. With the mode bit at 1, new codes are ORed into the bits already held.
- R10: With the mode bit at 0, any codeEvt pulse replaces bits 6..0 with that pulse's pattern.
- R11: A write to the code register loads the mode bit from data bit 7 and clears each code bit written as 0. A code event in the same cycle as the clear still wins.
- R12: The status register is read-only. Addresses 5 to 7 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for addr |
| stateEvt | input | 5 | Pulses: bus lock, overload sent, overrun, bus-off recovery, bus-off entry (bits 4..0) |
| codeEvt | input | 7 | Protocol error pulses, same order as code register bits 6..0 |
| txErrCnt | input | 8 | Transmit error counter value |
| rxErrCnt | input | 8 | Receive error counter value |
| warnActive | output | 1 | A counter is above the warning threshold |
| passActive | output | 1 | A counter is above the passive threshold |
| errIrq | output | 1 | Gated error interrupt |

## Verification
The bench aims at the cases where a write and an event collide on the same edge. A design that gave the clear priority would drop a flag or code that had just been reported. It steps the counters across 96, 97, 127 and 128, where an off-by-one comparison would move the warning or passive level by one count. It clears the warning flag while the counter stays high, which catches a design that sets the flag from the level instead of from its rising edge. It also switches between the two code display modes, where a mix-up would either stack codes that should have been replaced or lose codes that should have collected.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

  localparam int FLAG_W      = 8;
  localparam int CODE_W      = 7;
  localparam int STATE_EVT_W = FLAG_W - 3;
  localparam int ADDR_W      = 3;
  localparam int SUM_BIT     = 5;

  localparam int FLAG_BUS_ERR = 0;
  localparam int FLAG_WARN    = 1;
  localparam int FLAG_PASS    = 2;
  localparam int FLAG_STATE_LO = 3;

  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CODE = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_IEN  = 3'd4;

  typedef struct packed {
    logic wrFlag;
    logic wrEnable;
    logic wrCode;
    logic wrIen;
  } regStrobe_t;

endpackage

// File: rtl/can_err_ctrl.sv
module can_err_ctrl
  import can_err_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb
);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (addr)
        ADDR_FLAG: strb.wrFlag   = 1'b1;
        ADDR_EN:   strb.wrEnable = 1'b1;
        ADDR_CODE: strb.wrCode   = 1'b1;
        ADDR_IEN:  strb.wrIen    = 1'b1;
        default:   strb          = '0;
      endcase
    end
  end

endmodule

// File: rtl/can_err_thresh.sv
module can_err_thresh #(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96,
  parameter int PASS_LIMIT = 127,
  parameter int N_CNT      = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [N_CNT-1:0][CNT_W-1:0] cnt,
  output logic                       warnLvl,
  output logic                       passLvl,
  output logic                       warnRise,
  output logic                       passRise
);

  localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LIMIT);
  localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASS_LIMIT);

  logic [N_CNT-1:0] overWarn;
  logic [N_CNT-1:0] overPass;
  logic             warnQ;
  logic             passQ;

  for (genvar gi = 0; gi < N_CNT; gi++) begin : gCmp
    assign overWarn[gi] = cnt[gi] > WARN_C;
    assign overPass[gi] = cnt[gi] > PASS_C;
  end

  assign warnLvl = |overWarn;
  assign passLvl = |overPass;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warnQ <= 1'b0;
      passQ <= 1'b0;
    end else begin
      warnQ <= warnLvl;
      passQ <= passLvl;
    end
  end

  assign warnRise = warnLvl & ~warnQ;
  assign passRise = passLvl & ~passQ;

endmodule

// File: rtl/can_err_dp.sv
module can_err_dp
  import can_err_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strb,
  input  logic [7:0]             wrData,
  input  logic [STATE_EVT_W-1:0] stateEvt,
  input  logic [CODE_W-1:0]      codeEvt,
  input  logic                   warnRise,
  input  logic                   passRise,
  output logic [FLAG_W-1:0]      flagQ,
  output logic [FLAG_W-1:0]      enQ,
  output logic [CODE_W:0]        codeQ,
  output logic                   ieQ,
  output logic                   errSum
);

  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] flagKeep;
  logic [FLAG_W-1:0] flagNext;
  logic [CODE_W-1:0] codeKeep;
  logic [CODE_W-1:0] codeBits;
  logic [CODE_W-1:0] codeNext;
  logic              modeQ;
  logic              anyCode;

  assign anyCode = |codeEvt;

  always_comb begin
    setVec = '0;
    setVec[FLAG_W-1:FLAG_STATE_LO] = stateEvt;
    setVec[FLAG_PASS]    = passRise;
    setVec[FLAG_WARN]    = warnRise;
    setVec[FLAG_BUS_ERR] = anyCode;
  end

  // per-bit flag cells: a set always beats a zero-write clear
  for (genvar gi = 0; gi < FLAG_W; gi++) begin : gFlag
    assign flagKeep[gi] = ~(strb.wrFlag & ~wrData[gi]);
    assign flagNext[gi] = setVec[gi] | (flagQ[gi] & flagKeep[gi]);
  end

  // code bits: accumulate or show latest, depending on mode
  for (genvar gc = 0; gc < CODE_W; gc++) begin : gCode
    assign codeKeep[gc] = ~(strb.wrCode & ~wrData[gc]);
  end

  always_comb begin
    if (modeQ) begin
      codeNext = (codeBits & codeKeep) | codeEvt;
    end else if (anyCode) begin
      codeNext = codeEvt;
    end else begin
      codeNext = codeBits & codeKeep;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ    <= '0;
      enQ      <= '0;
      codeBits <= '0;
      modeQ    <= 1'b0;
      ieQ      <= 1'b0;
    end else begin
      flagQ    <= flagNext;
      codeBits <= codeNext;
      if (strb.wrEnable) begin
        enQ <= wrData;
      end
      if (strb.wrCode) begin
        modeQ <= wrData[CODE_W];
      end
      if (strb.wrIen) begin
        ieQ <= wrData[SUM_BIT];
      end
    end
  end

  assign codeQ  = {modeQ, codeBits};
  assign errSum = |(flagQ & enQ);

endmodule

// File: rtl/can_err_bank.sv
module can_err_bank
  import can_err_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int WARN_LIMIT = 96,
  parameter int PASS_LIMIT = 127
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wrData,
  output logic [7:0]             rdData,
  input  logic [STATE_EVT_W-1:0] stateEvt,
  input  logic [CODE_W-1:0]      codeEvt,
  input  logic [CNT_W-1:0]       txErrCnt,
  input  logic [CNT_W-1:0]       rxErrCnt,
  output logic                   warnActive,
  output logic                   passActive,
  output logic                   errIrq
);

  regStrobe_t          strb;
  logic [FLAG_W-1:0]   flagReg;
  logic [FLAG_W-1:0]   enReg;
  logic [CODE_W:0]     codeReg;
  logic                ieReg;
  logic                errSum;
  logic                warnRise;
  logic                passRise;
  logic [1:0][CNT_W-1:0] cntVec;

  assign cntVec = {rxErrCnt, txErrCnt};

  can_err_ctrl u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  can_err_thresh #(
    .CNT_W      (CNT_W),
    .WARN_LIMIT (WARN_LIMIT),
    .PASS_LIMIT (PASS_LIMIT),
    .N_CNT      (2)
  ) u_thresh (
    .clk      (clk),
    .rstN     (rstN),
    .cnt      (cntVec),
    .warnLvl  (warnActive),
    .passLvl  (passActive),
    .warnRise (warnRise),
    .passRise (passRise)
  );

  can_err_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .stateEvt (stateEvt),
    .codeEvt  (codeEvt),
    .warnRise (warnRise),
    .passRise (passRise),
    .flagQ    (flagReg),
    .enQ      (enReg),
    .codeQ    (codeReg),
    .ieQ      (ieReg),
    .errSum   (errSum)
  );

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_FLAG: rdData = flagReg;
      ADDR_EN:   rdData = enReg;
      ADDR_CODE: rdData = codeReg;
      ADDR_STAT: rdData[SUM_BIT] = errSum;
      ADDR_IEN:  rdData[SUM_BIT] = ieReg;
      default:   rdData = '0;
    endcase
  end

  assign errIrq = errSum & ieReg;

endmodule

// File: rtl/can_err_bank_chk.sv
module can_err_bank_chk
  import can_err_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic [ADDR_W-1:0]      addr,
  input logic [7:0]             wrData,
  input logic [STATE_EVT_W-1:0] stateEvt,
  input logic [CODE_W-1:0]      codeEvt,
  input logic                   warnActive,
  input logic                   passActive,
  input logic [FLAG_W-1:0]      flagReg,
  input logic [CODE_W:0]        codeReg
);

  // R2 / R4: a state pulse always leaves its flag set, clear or not
  a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stateEvt != '0) |=>
      ((flagReg[FLAG_W-1:FLAG_STATE_LO] & $past(stateEvt)) == $past(stateEvt)));

  // R3: without events, a flag write keeps exactly the bits written as 1
  a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_FLAG && stateEvt == '0) |=>
      (flagReg[FLAG_W-1:FLAG_STATE_LO] ==
       $past(flagReg[FLAG_W-1:FLAG_STATE_LO] & wrData[FLAG_W-1:FLAG_STATE_LO])));

  // R8: above the passive level implies above the warning level
  a_r8_pass_implies_warn: assert property (@(posedge clk) disable iff (!rstN)
    passActive |-> warnActive);

  // R9: accumulate mode never drops a code bit unless software writes
  a_r9_accumulate: assert property (@(posedge clk) disable iff (!rstN)
    (codeReg[CODE_W] && !(wrEn && addr == ADDR_CODE)) |=>
      ((codeReg[CODE_W-1:0] & $past(codeReg[CODE_W-1:0])) == $past(codeReg[CODE_W-1:0])));

  // R10: latest mode shows only the newest error pattern
  a_r10_latest_only: assert property (@(posedge clk) disable iff (!rstN)
    (!codeReg[CODE_W] && codeEvt != '0) |=> (codeReg[CODE_W-1:0] == $past(codeEvt)));

endmodule

bind can_err_bank can_err_bank_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .stateEvt   (stateEvt),
  .codeEvt    (codeEvt),
  .warnActive (warnActive),
  .passActive (passActive),
  .flagReg    (flagReg),
  .codeReg    (codeReg)
);

// File: tb/can_err_bank_tb.sv
`timescale 1ns/1ps
module can_err_bank_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [4:0] stateEvt = '0;
  logic [6:0] codeEvt = '0;
  logic [7:0] txErrCnt = '0;
  logic [7:0] rxErrCnt = '0;
  logic       warnActive;
  logic       passActive;
  logic       errIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  can_err_bank u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addr       (addr),
    .wrData     (wrData),
    .rdData     (rdData),
    .stateEvt   (stateEvt),
    .codeEvt    (codeEvt),
    .txErrCnt   (txErrCnt),
    .rxErrCnt   (rxErrCnt),
    .warnActive (warnActive),
    .passActive (passActive),
    .errIrq     (errIrq)
  );

  localparam logic [2:0] A_FLAG = 3'd0, A_EN = 3'd1, A_CODE = 3'd2,
                         A_STAT = 3'd3, A_IEN = 3'd4;

  typedef struct packed {
    logic       doWr;
    logic [2:0] wAddr;
    logic [7:0] wData;
    logic [4:0] sEvt;
    logic [6:0] cEvt;
    logic [7:0] tec;
    logic [7:0] rec;
    logic [2:0] rAddr;
    logic [7:0] expRd;
    logic       expIrq;
    logic [1:0] expLvl;
  } vec_t;

  localparam int N_VEC = 16;
  localparam vec_t VEC [N_VEC] = '{
    '{1'b0, A_FLAG, 8'h00, 5'b00000, 7'b0000000, 8'd0,  8'd0,   A_FLAG, 8'h00, 1'b0, 2'b00},
    '{1'b0, A_FLAG, 8'h00, 5'b10000, 7'b0000000, 8'd0,  8'd0,   A_FLAG, 8'h80, 1'b0, 2'b00},
    '{1'b1, A_EN,   8'h80, 5'b00000, 7'b0000000, 8'd0,  8'd0,   A_STAT, 8'h20, 1'b0, 2'b00},
    '{1'b1, A_IEN,  8'hFF, 5'b00000, 7'b0000000, 8'd0,  8'd0,   A_IEN,  8'h20, 1'b1, 2'b00},
    '{1'b1, A_FLAG, 8'h7F, 5'b00000, 7'b0000000, 8'd0,  8'd0,   A_FLAG, 8'h00, 1'b0, 2'b00},
    '{1'b0, A_FLAG, 8'h00, 5'b00000, 7'b0001000, 8'd0,  8'd0,   A_CODE, 8'h08, 1'b0, 2'b00},
    '{1'b0, A_FLAG, 8'h00, 5'b00000, 7'b0000001, 8'd0,  8'd0,   A_CODE, 8'h01, 1'b0, 2'b00},
    '{1'b1, A_CODE, 8'h80, 5'b00000, 7'b0000000, 8'd0,  8'd0,   A_CODE, 8'h80, 1'b0, 2'b00},
    '{1'b0, A_FLAG, 8'h00, 5'b00000, 7'b0100000, 8'd0,  8'd0,   A_CODE, 8'hA0, 1'b0, 2'b00},
    '{1'b0, A_FLAG, 8'h00, 5'b00000, 7'b0000010, 8'd0,  8'd0,   A_CODE, 8'hA2, 1'b0, 2'b00},
    '{1'b0, A_FLAG, 8'h00, 5'b00000, 7'b0000000, 8'd0,  8'd0,   A_FLAG, 8'h01, 1'b0, 2'b00},
    '{1'b1, A_EN,   8'h01, 5'b00000, 7'b0000000, 8'd0,  8'd0,   A_STAT, 8'h20, 1'b1, 2'b00},
    '{1'b0, A_FLAG, 8'h00, 5'b00000, 7'b0000000, 8'd97, 8'd0,   A_FLAG, 8'h03, 1'b1, 2'b10},
    '{1'b1, A_FLAG, 8'hFD, 5'b00000, 7'b0000000, 8'd97, 8'd0,   A_FLAG, 8'h01, 1'b1, 2'b10},
    '{1'b0, A_FLAG, 8'h00, 5'b00000, 7'b0000000, 8'd96, 8'd128, A_FLAG, 8'h05, 1'b1, 2'b11},
    '{1'b1, A_FLAG, 8'h00, 5'b00000, 7'b0000000, 8'd96, 8'd128, A_FLAG, 8'h00, 1'b0, 2'b11}
  };

  function automatic string vecTag(int idx);
    case (idx)
      0:       return "R1 idle";
      1:       return "R2 bus lock";
      2:       return "R5 summary";
      3:       return "R6 irq enable";
      4:       return "R3 clear one";
      5:       return "R9 code crc";
      6:       return "R10 overwrite";
      7:       return "R11 mode write";
      8, 9:    return "R9 accumulate";
      10:      return "R2 bus error flag";
      11:      return "R5 summary en";
      12:      return "R7 warn rise";
      13:      return "R7 no reset";
      14:      return "R8 pass rise";
      default: return "R5 drop";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then present read address for sampling
  task automatic step(input logic doWr, input logic [2:0] wA, input logic [7:0] wD,
                      input logic [4:0] sE, input logic [6:0] cE,
                      input logic [7:0] tec, input logic [7:0] rec,
                      input logic [2:0] rA);
    @(negedge clk);
    wrEn = doWr; addr = wA; wrData = wD;
    stateEvt = sE; codeEvt = cE;
    txErrCnt = tec; rxErrCnt = rec;
    @(negedge clk);
    wrEn = 1'b0; stateEvt = '0; codeEvt = '0; addr = rA;
    #1;
  endtask

  task automatic readAt(input logic [2:0] rA);
    addr = rA;
    #0.2;
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state of every register
    for (int a = 0; a < 5; a++) begin
      readAt(3'(a));
      chk("R1 reset reg", rdData, 8'h00);
    end
    chk("R1 reset irq", {7'b0, errIrq}, 8'h00);

    for (int i = 0; i < N_VEC; i++) begin
      step(VEC[i].doWr, VEC[i].wAddr, VEC[i].wData, VEC[i].sEvt, VEC[i].cEvt,
           VEC[i].tec, VEC[i].rec, VEC[i].rAddr);
      chk(vecTag(i), rdData, VEC[i].expRd);
      chk({vecTag(i), " irq"}, {7'b0, errIrq}, {7'b0, VEC[i].expIrq});
      chk({vecTag(i), " lvl"}, {6'b0, warnActive, passActive}, {6'b0, VEC[i].expLvl});
    end

    // R4: overrun pulse collides with a clear of all flags
    step(1'b0, A_FLAG, 8'h00, 5'b00100, 7'b0, 8'd96, 8'd128, A_FLAG);
    chk("R2 overrun set", rdData, 8'h20);
    step(1'b1, A_FLAG, 8'h00, 5'b00100, 7'b0, 8'd96, 8'd128, A_FLAG);
    chk("R4 event beats clear", rdData, 8'h20);

    // R11: ACK delimiter code collides with clearing every code bit
    step(1'b1, A_CODE, 8'h80, 5'b0, 7'b1000000, 8'd96, 8'd128, A_CODE);
    chk("R11 code event beats clear", rdData, 8'hC0);

    // tidy up: clear flags and codes, return code mode to latest
    step(1'b1, A_FLAG, 8'h00, 5'b0, 7'b0, 8'd96, 8'd128, A_FLAG);
    chk("R3 clear all", rdData, 8'h00);
    step(1'b1, A_CODE, 8'h00, 5'b0, 7'b0, 8'd96, 8'd128, A_CODE);
    chk("R11 code cleared", rdData, 8'h00);

    // R12: unmapped addresses and the read-only status register
    step(1'b1, 3'd5, 8'hFF, 5'b0, 7'b0, 8'd96, 8'd128, 3'd5);
    chk("R12 unmapped 5", rdData, 8'h00);
    readAt(3'd6);
    chk("R12 unmapped 6", rdData, 8'h00);
    readAt(3'd7);
    chk("R12 unmapped 7", rdData, 8'h00);
    readAt(A_FLAG);
    chk("R12 flags untouched", rdData, 8'h00);
    step(1'b1, A_STAT, 8'hFF, 5'b0, 7'b0, 8'd96, 8'd128, A_STAT);
    chk("R12 status read-only", rdData, 8'h00);
    readAt(A_EN);
    chk("R12 enable untouched", rdData, 8'h01);

    // R7 / R8: threshold boundaries
    step(1'b0, A_FLAG, 8'h00, 5'b0, 7'b0, 8'd0, 8'd96, A_FLAG);
    chk("R7 at 96 no warn", {6'b0, warnActive, passActive}, 8'h00);
    step(1'b0, A_FLAG, 8'h00, 5'b0, 7'b0, 8'd0, 8'd97, A_FLAG);
    chk("R7 at 97 warn", {6'b0, warnActive, passActive}, 8'h02);
    chk("R7 rx warn flag", rdData, 8'h02);
    step(1'b0, A_FLAG, 8'h00, 5'b0, 7'b0, 8'd127, 8'd0, A_FLAG);
    chk("R8 at 127 no pass", {6'b0, warnActive, passActive}, 8'h02);
    step(1'b0, A_FLAG, 8'h00, 5'b0, 7'b0, 8'd128, 8'd0, A_FLAG);
    chk("R8 at 128 pass", {6'b0, warnActive, passActive}, 8'h03);
    chk("R8 tx pass flag", rdData, 8'h06);

    // R1: reset in mid-run clears everything again
    @(negedge clk);
    rstN = 1'b0;
    txErrCnt = '0; rxErrCnt = '0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      readAt(3'(a));
      chk("R1 re-reset reg", rdData, 8'h00);
    end
    chk("R1 re-reset irq", {7'b0, errIrq}, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule